// File: doc/BRIEF.md
# Software Cell Enqueue Doorbell

This block lets software pass a single transmit descriptor to a cell segmentation engine, with no scheduler involved. Software writes one 32-bit word to the enqueue register. The upper bits of that word give a 128-byte-aligned descriptor address and the low seven bits give a cell-type code. The block holds the word and drives a valid/ready request toward the engine. While the request is waiting, a read of the enqueue register returns the written word. Once the engine has taken the request, the same read returns zero, so the register also serves as the busy flag. For this reason a descriptor address of zero is never legal.

When the engine has built and queued a cell, it offers the descriptor address on a second valid/ready channel. The block keeps that address in a one-entry completion slot. Software reads the slot, and the read empties it. While the slot is occupied, the block holds the engine's completion ready low, which stalls the engine.

Two small state machines do the work. The enqueue machine has the states ENQ_IDLE and ENQ_PEND. Its transitions are ACCEPT_WRITE (ENQ_IDLE to ENQ_PEND, on a legal write) and HANDOFF (ENQ_PEND to ENQ_IDLE, when the engine's ready is high). The completion machine has the states SLOT_EMPTY and SLOT_FULL. Its transitions are POST (SLOT_EMPTY to SLOT_FULL, when the engine's valid is high) and DRAIN (SLOT_FULL to SLOT_EMPTY, on a software read of the slot). Register select 0 addresses the enqueue register and select 1 addresses the completion slot. Writes with select 1 have no effect.

Top module: `swq_doorbell`

## Requirements
- R1: After reset, no request is raised and the completion channel is ready. Both error flags are low, and reads of both registers return zero.
- R2: In the enqueue word, bits 31:7 are the descriptor address and bits 6:0 are the cell-type code. A legal write raises req_valid, with req_addr equal to bits 31:7 and req_ctype equal to bits 6:0.
- R3: Only the cell-type codes 0x00 (normal) and 0x7F (rate-managed) are legal. A write in ENQ_IDLE with any other code starts no request. Instead, type_err is high for exactly the one cycle after the write.
- R4: A write in ENQ_IDLE whose address field (bits 31:7) is zero starts no request and raises type_err for one cycle.
- R5: While a request is pending, a read of the enqueue register returns the word that was written. Once the request has been accepted, the read returns zero.
- R6: req_valid stays high, with req_addr and req_ctype unchanged, until a cycle in which req_ready is high. In the following cycle req_valid is low.
- R7: A write to the enqueue register while a request is pending is dropped. The pending address and type stay as they were, and ovr_flag goes high and stays high until reset.
- R8: A completion is taken in a cycle where both cmp_valid and cmp_ready are high. After that, cmp_ready stays low for as long as the slot is occupied.
- R9: A read of the completion slot returns bits 31:7 equal to the stored address, bits 6:1 equal to zero and bit 0 (valid) equal to 1, and the read empties the slot. cmp_ready is high again in the next cycle. A read of an empty slot returns zero.
- R10: Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 = enqueue, 1 = completion |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_valid | output | 1 | Request to the engine is pending |
| req_ready | input | 1 | Engine takes the request |
| req_addr | output | 25 | Descriptor address (bits 31:7) |
| req_ctype | output | 7 | Cell-type code |
| cmp_valid | input | 1 | Engine offers a completion |
| cmp_ready | output | 1 | Completion slot is free |
| cmp_addr | input | 25 | Completed descriptor address |
| type_err | output | 1 | One-cycle pulse for an illegal write |
| ovr_flag | output | 1 | Sticky: a write arrived while a request was pending |

## Verification
The hardest case to reach is a second completion waiting behind an occupied slot while software drains the slot. The bench reaches it by posting one completion and then keeping cmp_valid high with a second address. It checks that cmp_ready stays low over several cycles. It then reads the slot and confirms three things: the first address comes back, cmp_ready rises in the cycle straight after the read, and the waiting address is taken on the next edge. The overrun case is reached by holding req_ready low and writing a second word on top of a pending one.

// File: rtl/swq_pkg.sv
package swq_pkg;

    typedef enum logic {
        ENQ_IDLE = 1'b0,
        ENQ_PEND = 1'b1
    } enq_state_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/swq_enq_fsm.sv
module swq_enq_fsm
    import swq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TYPE_W = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        req_ready,
    output logic                        req_valid,
    output logic [DATA_W-TYPE_W-1:0]    req_addr,
    output logic [TYPE_W-1:0]           req_ctype,
    output logic                        type_err,
    output logic                        ovr_flag
);
    localparam int AW = DATA_W - TYPE_W;

    enq_state_e state_q, state_d;

    logic [AW-1:0]     wr_addr;
    logic [TYPE_W-1:0] wr_type;
    logic              type_legal;
    logic              wr_ok;
    logic              err_q;
    logic              ovr_q;
    logic [AW-1:0]     addr_q;
    logic [TYPE_W-1:0] type_q;

    assign wr_addr    = wdata[DATA_W-1:TYPE_W];
    assign wr_type    = wdata[TYPE_W-1:0];
    // legal codes: all zeros (normal) or all ones (rate-managed)
    assign type_legal = (wr_type == '0) || (wr_type == '1);
    assign wr_ok      = type_legal && (wr_addr != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENQ_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT_WRITE and HANDOFF
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENQ_IDLE: if (wr_en && wr_ok) state_d = ENQ_PEND;
            ENQ_PEND: if (req_ready)      state_d = ENQ_IDLE;
        endcase
    end

    // held request fields and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            type_q <= '0;
            err_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                ENQ_IDLE: begin
                    if (wr_en && wr_ok) begin
                        addr_q <= wr_addr;
                        type_q <= wr_type;
                    end
                    err_q <= wr_en && !wr_ok;
                end
                ENQ_PEND: begin
                    if (wr_en) ovr_q <= 1'b1;
                end
            endcase
        end
    end

    assign req_valid = (state_q == ENQ_PEND);
    assign req_addr  = addr_q;
    assign req_ctype = type_q;
    assign type_err  = err_q;
    assign ovr_flag  = ovr_q;

endmodule

// File: rtl/swq_cmp_slot.sv
module swq_cmp_slot
    import swq_pkg::*;
#(
    parameter int AW = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_valid,
    input  logic [AW-1:0] cmp_addr,
    input  logic          rd_clr,
    output logic          cmp_ready,
    output logic          full,
    output logic [AW-1:0] slot_addr
);
    slot_state_e state_q, state_d;
    logic [AW-1:0] addr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: POST and DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (cmp_valid) state_d = SLOT_FULL;
            SLOT_FULL:  if (rd_clr)    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                 addr_q <= '0;
        else if (state_q == SLOT_EMPTY && cmp_valid) addr_q <= cmp_addr;
    end

    assign cmp_ready = (state_q == SLOT_EMPTY);
    assign full      = (state_q == SLOT_FULL);
    assign slot_addr = addr_q;

endmodule

// File: rtl/swq_doorbell.sv
module swq_doorbell #(
    parameter int DATA_W = 32,
    parameter int TYPE_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic                     bus_sel,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [DATA_W-TYPE_W-1:0] req_addr,
    output logic [TYPE_W-1:0]        req_ctype,
    input  logic                     cmp_valid,
    output logic                     cmp_ready,
    input  logic [DATA_W-TYPE_W-1:0] cmp_addr,
    output logic                     type_err,
    output logic                     ovr_flag
);
    localparam int AW = DATA_W - TYPE_W;

    logic          enq_wr;
    logic          slot_clr;
    logic          slot_full;
    logic [AW-1:0] slot_addr;
    logic [DATA_W-1:0] rdata_q;

    assign enq_wr   = bus_wr && !bus_sel;
    assign slot_clr = bus_rd && bus_sel;

    swq_enq_fsm #(.DATA_W(DATA_W), .TYPE_W(TYPE_W)) u_enq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (enq_wr),
        .wdata     (bus_wdata),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ctype (req_ctype),
        .type_err  (type_err),
        .ovr_flag  (ovr_flag)
    );

    swq_cmp_slot #(.AW(AW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .cmp_addr  (cmp_addr),
        .rd_clr    (slot_clr),
        .cmp_ready (cmp_ready),
        .full      (slot_full),
        .slot_addr (slot_addr)
    );

    // registered read mux: data is the register state before the strobe edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            if (!bus_sel)
                rdata_q <= req_valid ? {req_addr, req_ctype} : '0;
            else
                rdata_q <= slot_full ? {slot_addr, {(TYPE_W-1){1'b0}}, 1'b1} : '0;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/swq_doorbell_chk.sv
module swq_doorbell_chk #(
    parameter int DATA_W = 32,
    parameter int TYPE_W = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [DATA_W-TYPE_W-1:0] req_addr,
    input logic [TYPE_W-1:0]        req_ctype,
    input logic                     cmp_valid,
    input logic                     cmp_ready,
    input logic                     type_err,
    input logic                     ovr_flag
);
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_ctype));

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid);

    assert_req_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_ctype == '0) || (req_ctype == '1));

    assert_err_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        type_err |-> !req_valid);

    assert_req_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr != '0);

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);

    assert_post_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready |=> !cmp_ready);

endmodule

bind swq_doorbell swq_doorbell_chk #(.DATA_W(DATA_W), .TYPE_W(TYPE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_ctype (req_ctype),
    .cmp_valid (cmp_valid),
    .cmp_ready (cmp_ready),
    .type_err  (type_err),
    .ovr_flag  (ovr_flag)
);

// File: tb/tb_swq_doorbell.sv
`timescale 1ns/1ps
module tb_swq_doorbell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [24:0] req_addr;
    logic [6:0]  req_ctype;
    logic        cmp_valid = 1'b0;
    logic        cmp_ready;
    logic [24:0] cmp_addr = '0;
    logic        type_err;
    logic        ovr_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    swq_doorbell dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_ctype(req_ctype), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
        .cmp_addr(cmp_addr), .type_err(type_err), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic sel, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = sel;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic accept_req();
        @(negedge clk);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic post_cmp(input logic [24:0] a);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_addr = a;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
        chk("R1 cmp_ready", {31'd0, cmp_ready}, 32'd1);
        chk("R1 flags", {30'd0, type_err, ovr_flag}, 32'd0);
        do_read(1'b0, v); chk("R1 enqueue read", v, 32'd0);
        do_read(1'b1, v); chk("R1 completion read", v, 32'd0);
    endtask

    task automatic t_normal();
        logic [31:0] v;
        do_write(1'b0, {25'h0000123, 7'h00});
        chk("R2 req_valid", {31'd0, req_valid}, 32'd1);
        chk("R2 req_addr", {7'd0, req_addr}, 32'h0000123);
        chk("R2 req_ctype", {25'd0, req_ctype}, 32'h00);
        repeat (3) @(negedge clk);
        chk("R6 held", {req_valid, req_addr, req_ctype}, {1'b1, 25'h0000123, 7'h00});
        do_read(1'b0, v);
        chk("R5 pending readback", v, {25'h0000123, 7'h00});
        chk("R10 rdata holds", bus_rdata, {25'h0000123, 7'h00});
        accept_req();
        chk("R6 dropped after ready", {31'd0, req_valid}, 32'd0);
        do_read(1'b0, v);
        chk("R5 ready readback", v, 32'd0);
    endtask

    task automatic t_abr();
        do_write(1'b0, {25'h1ABCDEF, 7'h7F});
        chk("R2 abr ctype", {25'd0, req_ctype}, 32'h7F);
        chk("R2 abr addr", {7'd0, req_addr}, 32'h1ABCDEF);
        chk("R3 legal no err", {31'd0, type_err}, 32'd0);
        accept_req();
        chk("R6 abr dropped", {31'd0, req_valid}, 32'd0);
    endtask

    task automatic t_bad_type();
        do_write(1'b0, {25'h0000456, 7'h05});
        chk("R3 err pulse", {31'd0, type_err}, 32'd1);
        chk("R3 no request", {31'd0, req_valid}, 32'd0);
        @(negedge clk);
        chk("R3 err one cycle", {31'd0, type_err}, 32'd0);
        do_write(1'b0, {25'h0000456, 7'h40});
        chk("R3 err pulse 0x40", {31'd0, type_err}, 32'd1);
        chk("R3 no request 0x40", {31'd0, req_valid}, 32'd0);
    endtask

    task automatic t_zero_addr();
        do_write(1'b0, {25'h0, 7'h7F});
        chk("R4 err pulse", {31'd0, type_err}, 32'd1);
        chk("R4 no request", {31'd0, req_valid}, 32'd0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        chk("R7 clear before", {31'd0, ovr_flag}, 32'd0);
        do_write(1'b0, {25'h0000AAA, 7'h00});
        do_write(1'b0, {25'h0000BBB, 7'h7F});
        chk("R7 overrun set", {31'd0, ovr_flag}, 32'd1);
        chk("R7 request kept", {7'd0, req_addr}, 32'h0000AAA);
        chk("R7 type kept", {25'd0, req_ctype}, 32'h00);
        chk("R7 no type err", {31'd0, type_err}, 32'd0);
        do_read(1'b0, v);
        chk("R7 readback kept", v, {25'h0000AAA, 7'h00});
        accept_req();
        repeat (2) @(negedge clk);
        chk("R7 sticky", {31'd0, ovr_flag}, 32'd1);
    endtask

    task automatic t_completion();
        logic [31:0] v;
        post_cmp(25'h0000777);
        chk("R8 ready low when full", {31'd0, cmp_ready}, 32'd0);
        do_read(1'b1, v);
        chk("R9 slot read", v, {25'h0000777, 6'd0, 1'b1});
        chk("R9 ready after read", {31'd0, cmp_ready}, 32'd1);
        do_read(1'b1, v);
        chk("R9 empty read", v, 32'd0);
    endtask

    task automatic t_backpressure();
        logic [31:0] v;
        post_cmp(25'h1000F0F);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_addr = 25'h0333333;
        chk("R8 stall start", {31'd0, cmp_ready}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R8 stall held", {31'd0, cmp_ready}, 32'd0);
        do_read(1'b1, v);
        chk("R9 first out", v, {25'h1000F0F, 6'd0, 1'b1});
        chk("R9 ready next cycle", {31'd0, cmp_ready}, 32'd1);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk("R8 second taken", {31'd0, cmp_ready}, 32'd0);
        do_read(1'b1, v);
        chk("R9 second out", v, {25'h0333333, 6'd0, 1'b1});
        chk("R9 drained", {31'd0, cmp_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_abr();
        t_bad_type();
        t_zero_addr();
        t_completion();
        t_backpressure();
        t_overrun();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule